// File: doc/BRIEF.md
# QoS Way-Partitioned Cache Allocator

This unit sits beside one slice of a shared last-level cache and decides where a line fill goes. Each fill names the set, the quality-of-service domain of the requester (a core, a virtual machine, an IO device or a virtual function) and whether the access is an instruction fetch or a data access. For every domain the unit holds two way masks, one per access class. A fill may replace only a way whose bit is set in the selected mask. Within those ways an empty way is taken first. When no allowed way is empty, a round-robin pointer kept for each set chooses the victim. If the selected mask is empty, the fill is not placed and the unit reports a bypass.

The unit also counts how many lines each domain holds in this slice. On every placed fill it charges the line to the requesting domain and removes it from the domain that owned the evicted line. The caller supplies the owner of each way in the set with the request. Tag lookup and the data arrays belong to the surrounding cache. Masks are written, and counters are read, through a small side port.

Top module: `qos_way_alloc`

## Requirements
- R1: After reset, every mask bit of every domain and class is 1, every occupancy counter reads 0, every set's round-robin pointer is way 0, and alloc_valid is low.
- R2: A fill accepted at a clock edge produces alloc_valid high for exactly the following cycle, together with alloc_bypass and alloc_way. alloc_valid is low in every cycle that does not follow a fill.
- R3: The chosen way always has its bit set in the mask selected by fill_qos and fill_instr. fill_instr=1 selects the instruction mask and fill_instr=0 selects the data mask. Bit i of a mask stands for way i.
- R4: When some allowed way has fill_way_valid low, the lowest-numbered such way is chosen, and the set's pointer does not change.
- R5: When every allowed way is valid, the chosen way is the first allowed way at or after the set's pointer, counting upward and wrapping from the top way to way 0. The pointer then becomes that way plus one, modulo the way count. Each set has its own pointer.
- R6: An all-zero selected mask gives alloc_bypass=1 and alloc_way=0, and leaves every counter and pointer unchanged.
- R7: On a placed fill, the requester's counter rises by one and saturates at 2^CNT_W-1. If the victim way was valid, its owner's counter falls by one and never goes below 0. When the owner of the valid victim is the requester itself, the count stays the same.
- R8: occ_count combinationally shows the counter of the domain on occ_qos, including updates made at the last edge.
- R9: A mask write takes effect for fills from the next edge onward. A fill accepted at the same edge as a write to its own mask uses the old mask.
- R10: The masks of different domains, and the instruction and data masks of one domain, are stored and applied independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Fill request present |
| fill_set | input | $clog2(NUM_SETS) | Set index of the fill |
| fill_qos | input | $clog2(NUM_QOS) | Requesting QoS domain |
| fill_instr | input | 1 | 1 = instruction access, 0 = data access |
| fill_way_valid | input | NUM_WAYS | Valid bit of each way in the set |
| fill_way_owner | input | NUM_WAYS*$clog2(NUM_QOS) | Owner domain of each way, way i in bits [i*QW +: QW] |
| mask_we | input | 1 | Mask write strobe |
| mask_qos | input | $clog2(NUM_QOS) | Domain whose mask is written |
| mask_instr | input | 1 | 1 = write the instruction mask, 0 = write the data mask |
| mask_wdata | input | NUM_WAYS | New mask value |
| occ_qos | input | $clog2(NUM_QOS) | Domain whose counter is read |
| occ_count | output | CNT_W | Occupancy of domain occ_qos |
| alloc_valid | output | 1 | Allocation result valid |
| alloc_bypass | output | 1 | Fill not placed: empty mask |
| alloc_way | output | $clog2(NUM_WAYS) | Way chosen for the fill |

## Verification
Two events can fall in the same cycle: a mask write, and a fill that reads the very mask being written. The bench drives both at one edge, with a new value that would send the fill to a different way or to a bypass. It judges the result against a model that applies the old mask first. The bench also lets counter updates for the evicting and the evicted domain land at the same edge. It checks both counters right after that edge, under long random runs that drive small counters into saturation and down to zero.

// File: rtl/qos_alloc_pkg.sv
package qos_alloc_pkg;

    // access class selecting one of the two masks of a domain
    typedef enum logic {
        CLS_DATA  = 1'b0,
        CLS_INSTR = 1'b1
    } acc_class_e;

    // how the victim way was obtained
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_FREE = 2'd1,
        PICK_RR   = 2'd2
    } pick_src_e;

endpackage

// File: rtl/qos_mask_bank.sv
module qos_mask_bank
    import qos_alloc_pkg::*;
#(
    parameter int NUM_QOS  = 16,
    parameter int NUM_WAYS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(NUM_QOS)-1:0] wr_qos,
    input  acc_class_e                 wr_cls,
    input  logic [NUM_WAYS-1:0]        wr_mask,
    input  logic [$clog2(NUM_QOS)-1:0] rd_qos,
    input  acc_class_e                 rd_cls,
    output logic [NUM_WAYS-1:0]        rd_mask
);
    logic [NUM_WAYS-1:0] imask_q [NUM_QOS];
    logic [NUM_WAYS-1:0] dmask_q [NUM_QOS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NUM_QOS; q++) begin
                imask_q[q] <= '1;
                dmask_q[q] <= '1;
            end
        end else if (wr_en) begin
            if (wr_cls == CLS_INSTR) imask_q[wr_qos] <= wr_mask;
            else                     dmask_q[wr_qos] <= wr_mask;
        end
    end

    assign rd_mask = (rd_cls == CLS_INSTR) ? imask_q[rd_qos] : dmask_q[rd_qos];

endmodule

// File: rtl/qos_victim_sel.sv
module qos_victim_sel
    import qos_alloc_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    parameter int NUM_SETS = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fill_valid,
    input  logic [$clog2(NUM_SETS)-1:0] fill_set,
    input  logic [NUM_WAYS-1:0]         mask,
    input  logic [NUM_WAYS-1:0]         way_valid,
    output logic [$clog2(NUM_WAYS)-1:0] pick_way,
    output pick_src_e                   pick_src
);
    localparam int WW = $clog2(NUM_WAYS);

    logic [WW-1:0]       ptr_q [NUM_SETS];
    logic [WW-1:0]       ptr_cur;
    logic [NUM_WAYS-1:0] free;
    logic                free_hit, rr_hit;
    logic [WW-1:0]       free_way, rr_way;
    int                  idx_c;

    always_comb begin
        free     = mask & ~way_valid;
        ptr_cur  = ptr_q[fill_set];
        free_hit = 1'b0;
        free_way = '0;
        rr_hit   = 1'b0;
        rr_way   = '0;
        idx_c    = 0;
        // descending scans: the last hit written is the lowest index / offset
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (free[i]) begin
                free_hit = 1'b1;
                free_way = WW'(i);
            end
        end
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            idx_c = (int'(ptr_cur) + i) % NUM_WAYS;
            if (mask[idx_c]) begin
                rr_hit = 1'b1;
                rr_way = WW'(idx_c);
            end
        end
        if (free_hit) begin
            pick_src = PICK_FREE;
            pick_way = free_way;
        end else if (rr_hit) begin
            pick_src = PICK_RR;
            pick_way = rr_way;
        end else begin
            pick_src = PICK_NONE;
            pick_way = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) ptr_q[s] <= '0;
        end else if (fill_valid && pick_src == PICK_RR) begin
            ptr_q[fill_set] <= (pick_way == WW'(NUM_WAYS - 1)) ? '0 : pick_way + 1'b1;
        end
    end

    p_in_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && (|mask)) |-> mask[pick_way]);

    p_free_first_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && (|(mask & ~way_valid))) |-> !way_valid[pick_way]);

    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && pick_src != PICK_RR) |=> ptr_q[$past(fill_set)] == $past(ptr_cur));

endmodule

// File: rtl/qos_occupancy.sv
module qos_occupancy #(
    parameter int NUM_QOS = 16,
    parameter int CNT_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd,
    input  logic [$clog2(NUM_QOS)-1:0] inc_id,
    input  logic                       dec_en,
    input  logic [$clog2(NUM_QOS)-1:0] dec_id,
    input  logic [$clog2(NUM_QOS)-1:0] rd_id,
    output logic [CNT_W-1:0]           rd_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NUM_QOS];
    logic             same_id;

    assign same_id = dec_en && (dec_id == inc_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NUM_QOS; q++) cnt_q[q] <= '0;
        end else if (upd && !same_id) begin
            if (cnt_q[inc_id] != CNT_MAX) cnt_q[inc_id] <= cnt_q[inc_id] + 1'b1;
            if (dec_en && cnt_q[dec_id] != '0) cnt_q[dec_id] <= cnt_q[dec_id] - 1'b1;
        end
    end

    assign rd_cnt = cnt_q[rd_id];

    p_floor_r7: assert property (@(posedge clk) disable iff (rst)
        (upd && dec_en && dec_id != inc_id && cnt_q[dec_id] == '0) |=> cnt_q[$past(dec_id)] == '0);

    p_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (upd && !same_id && cnt_q[inc_id] == CNT_MAX) |=> cnt_q[$past(inc_id)] == CNT_MAX);

endmodule

// File: rtl/qos_way_alloc.sv
module qos_way_alloc
    import qos_alloc_pkg::*;
#(
    parameter int NUM_QOS  = 16,
    parameter int NUM_WAYS = 16,
    parameter int NUM_SETS = 16,
    parameter int CNT_W    = 12
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        fill_valid,
    input  logic [$clog2(NUM_SETS)-1:0]                 fill_set,
    input  logic [$clog2(NUM_QOS)-1:0]                  fill_qos,
    input  logic                                        fill_instr,
    input  logic [NUM_WAYS-1:0]                         fill_way_valid,
    input  logic [NUM_WAYS*$clog2(NUM_QOS)-1:0]         fill_way_owner,
    input  logic                                        mask_we,
    input  logic [$clog2(NUM_QOS)-1:0]                  mask_qos,
    input  logic                                        mask_instr,
    input  logic [NUM_WAYS-1:0]                         mask_wdata,
    input  logic [$clog2(NUM_QOS)-1:0]                  occ_qos,
    output logic [CNT_W-1:0]                            occ_count,
    output logic                                        alloc_valid,
    output logic                                        alloc_bypass,
    output logic [$clog2(NUM_WAYS)-1:0]                 alloc_way
);
    localparam int QW = $clog2(NUM_QOS);
    localparam int WW = $clog2(NUM_WAYS);

    logic [NUM_WAYS-1:0] sel_mask;
    logic [WW-1:0]       pick_way;
    pick_src_e           pick_src;
    logic                placed;
    logic [QW-1:0]       victim_owner;

    qos_mask_bank #(.NUM_QOS(NUM_QOS), .NUM_WAYS(NUM_WAYS)) u_masks (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mask_we),
        .wr_qos  (mask_qos),
        .wr_cls  (acc_class_e'(mask_instr)),
        .wr_mask (mask_wdata),
        .rd_qos  (fill_qos),
        .rd_cls  (acc_class_e'(fill_instr)),
        .rd_mask (sel_mask)
    );

    qos_victim_sel #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .fill_valid (fill_valid),
        .fill_set   (fill_set),
        .mask       (sel_mask),
        .way_valid  (fill_way_valid),
        .pick_way   (pick_way),
        .pick_src   (pick_src)
    );

    assign placed       = fill_valid && (pick_src != PICK_NONE);
    assign victim_owner = fill_way_owner[pick_way*QW +: QW];

    qos_occupancy #(.NUM_QOS(NUM_QOS), .CNT_W(CNT_W)) u_occ (
        .clk    (clk),
        .rst    (rst),
        .upd    (placed),
        .inc_id (fill_qos),
        .dec_en (fill_way_valid[pick_way]),
        .dec_id (victim_owner),
        .rd_id  (occ_qos),
        .rd_cnt (occ_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_valid  <= 1'b0;
            alloc_bypass <= 1'b0;
            alloc_way    <= '0;
        end else begin
            alloc_valid  <= fill_valid;
            alloc_bypass <= fill_valid && (pick_src == PICK_NONE);
            alloc_way    <= fill_valid ? pick_way : '0;
        end
    end

    p_result_follows_r2: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> alloc_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !fill_valid |=> !alloc_valid);

    p_bypass_on_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && sel_mask == '0) |=> (alloc_bypass && alloc_way == '0));

endmodule

// File: tb/sim_qos_way_alloc.sv
`timescale 1ns/1ps
module sim_qos_way_alloc;
    localparam int NQ = 16;
    localparam int NW = 16;
    localparam int NS = 4;
    localparam int CW = 3;
    localparam int CMAX = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_set = '0;
    logic [3:0]  fill_qos = '0;
    logic        fill_instr = 1'b0;
    logic [15:0] fill_way_valid = '0;
    logic [63:0] fill_way_owner = '0;
    logic        mask_we = 1'b0;
    logic [3:0]  mask_qos = '0;
    logic        mask_instr = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic [3:0]  occ_qos = '0;
    logic [2:0]  occ_count;
    logic        alloc_valid, alloc_bypass;
    logic [3:0]  alloc_way;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [15:0] m_im [NQ];
    logic [15:0] m_dm [NQ];
    int          m_rr [NS];
    int          m_cnt [NQ];

    always #4 clk = ~clk;

    qos_way_alloc #(.NUM_QOS(NQ), .NUM_WAYS(NW), .NUM_SETS(NS), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_set(fill_set),
        .fill_qos(fill_qos), .fill_instr(fill_instr), .fill_way_valid(fill_way_valid),
        .fill_way_owner(fill_way_owner), .mask_we(mask_we), .mask_qos(mask_qos),
        .mask_instr(mask_instr), .mask_wdata(mask_wdata), .occ_qos(occ_qos),
        .occ_count(occ_count), .alloc_valid(alloc_valid), .alloc_bypass(alloc_bypass),
        .alloc_way(alloc_way)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic read_cnt(input int q, input string tag);
        occ_qos = 4'(q);
        #0.5;
        chk(int'(occ_count) == m_cnt[q], tag, occ_count, m_cnt[q]);
    endtask

    // one fill, optionally with a mask write at the same edge (R9)
    task automatic do_fill(input int s, input int q, input bit ins, input logic [15:0] vv,
                           input logic [63:0] own, input bit wr, input int wq,
                           input bit wi, input logic [15:0] wm);
        logic [15:0] m;
        logic [15:0] fr;
        bit byp;
        bit by_rr;
        int w;
        int ow;
        @(negedge clk);
        fill_valid = 1'b1; fill_set = 2'(s); fill_qos = 4'(q); fill_instr = ins;
        fill_way_valid = vv; fill_way_owner = own;
        mask_we = wr; mask_qos = 4'(wq); mask_instr = wi; mask_wdata = wm;
        m = ins ? m_im[q] : m_dm[q];
        byp = (m == 16'h0);
        by_rr = 1'b0;
        w = 0;
        ow = 0;
        if (!byp) begin
            fr = m & ~vv;
            if (fr != 16'h0) begin
                for (int i = NW - 1; i >= 0; i--) if (fr[i]) w = i;
            end else begin
                by_rr = 1'b1;
                for (int i = NW - 1; i >= 0; i--) if (m[(m_rr[s] + i) % NW]) w = (m_rr[s] + i) % NW;
                m_rr[s] = (w + 1) % NW;
            end
            ow = int'(own[w*4 +: 4]);
            if (!(vv[w] && ow == q)) begin
                if (m_cnt[q] < CMAX) m_cnt[q]++;
                if (vv[w] && m_cnt[ow] > 0) m_cnt[ow]--;
            end
        end
        if (wr) begin
            if (wi) m_im[wq] = wm; else m_dm[wq] = wm;
        end
        @(negedge clk);
        fill_valid = 1'b0; mask_we = 1'b0;
        chk(alloc_valid == 1'b1, "R2 valid after fill", alloc_valid, 1);
        chk(alloc_bypass == byp, byp ? "R6 bypass" : "R6 no bypass", alloc_bypass, byp);
        chk(int'(alloc_way) == w, byp ? "R6 way" : (by_rr ? "R5 rr way" : "R4 free way"),
            alloc_way, w);
        if (!byp) chk(m[alloc_way] == 1'b1, "R3 way in mask", alloc_way, w);
        read_cnt(q, "R7 requester count");
        if (!byp && vv[w]) read_cnt(ow, "R7 evicted owner count");
        @(negedge clk);
        chk(alloc_valid == 1'b0, "R2 single cycle", alloc_valid, 0);
    endtask

    task automatic wr_mask(input int q, input bit ins, input logic [15:0] m);
        @(negedge clk);
        mask_we = 1'b1; mask_qos = 4'(q); mask_instr = ins; mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
        if (ins) m_im[q] = m; else m_dm[q] = m;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [15:0] vv;
        logic [63:0] own;
        for (int q = 0; q < NQ; q++) begin
            m_im[q] = 16'hFFFF; m_dm[q] = 16'hFFFF; m_cnt[q] = 0;
        end
        for (int s = 0; s < NS; s++) m_rr[s] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(alloc_valid == 1'b0, "R1 alloc_valid reset", alloc_valid, 0);
        for (int q = 0; q < NQ; q++) begin
            @(negedge clk);
            read_cnt(q, "R1 counter reset");
        end
        // R1: masks reset to all ones, probed by the one free way
        for (int q = 0; q < NQ; q++) begin
            for (int i = 0; i < 2; i++) begin
                do_fill(q % NS, q, i[0], ~(16'h1 << ((q * 2 + i) % NW)), 64'h0, 0, 0, 0, 16'h0);
            end
        end
        // R1/R5: pointer starts at 0 and walks every way with a full mask
        for (int k = 0; k < 20; k++) do_fill(1, 15, 1'b1, 16'hFFFF, {16{4'hA}}, 0, 0, 0, 16'h0);
        // R10: distinct masks per domain and class
        for (int q = 0; q < NQ - 1; q++) begin
            logic [15:0] im;
            im = (16'h1 << q) | (16'h1 << ((q + 5) % NW)) | (16'h1 << ((q + 9) % NW));
            wr_mask(q, 1'b1, (q == 3) ? 16'h0 : im);
            wr_mask(q, 1'b0, (q == 7) ? 16'h0 : ~im);
        end
        // R6: empty masks
        do_fill(2, 3, 1'b1, 16'h0000, 64'h0, 0, 0, 0, 16'h0);
        do_fill(2, 7, 1'b0, 16'hFFFF, 64'h0, 0, 0, 0, 16'h0);
        // R9: same-edge write to the mask the fill reads
        do_fill(0, 2, 1'b0, 16'h0000, 64'h0, 1, 2, 0, 16'h8000);
        do_fill(0, 2, 1'b0, 16'h0000, 64'h0, 0, 0, 0, 16'h0);
        do_fill(0, 4, 1'b1, 16'hFFFF, 64'h0, 1, 4, 1, 16'h0000);
        do_fill(0, 4, 1'b1, 16'hFFFF, 64'h0, 0, 0, 0, 16'h0);
        // random sweep; masks reshuffled halfway (R10)
        r = 32'h1234_5679;
        for (int n = 0; n < 1200; n++) begin
            if (n == 600) begin
                for (int q = 0; q < NQ; q++) begin
                    r = xs(r);
                    wr_mask(q, 1'b0, r[15:0]);
                    wr_mask(q, 1'b1, r[31:16]);
                end
            end
            r = xs(r);
            vv = (r[3:0] < 4'd10) ? 16'hFFFF : (r[31:16] | r[15:0]);
            own[31:0] = xs(r + 32'h9E37_79B9);
            own[63:32] = xs(own[31:0]);
            r = xs(r);
            do_fill(int'(r[1:0]), int'(r[7:4]), r[8], vv, own, 0, 0, 0, 16'h0);
        end
        // R8: final counter readout for every domain
        for (int q = 0; q < NQ; q++) begin
            @(negedge clk);
            read_cnt(q, "R8 final counter");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule